// File: doc/BRIEF.md
# Serial Clock and Parameter RAM Slave

This block is a three-wire serial slave that keeps a running 32-bit count of seconds and a small byte-wide parameter store. A host drives three lines of a general-purpose port: an active-low select, a serial clock, and a data line. The data line is bidirectional, and a separate direction bit tells the block which way the line is being driven. The host toggles the clock by software. While it drives the data line, it shifts command and data bytes into the block MSB first. After a read command it turns the data line around and clocks the reply byte back out, also MSB first.

Each byte carries a command code, and the code selects the operation. The operations are: read or load one byte of the seconds count, read or write a four-byte window at the bottom of the store, a two-stage extended access (a sector in the command, then an address byte) that reaches deeper into the store, a write-protect flag, and an inert test code. A prescaler divides the system clock down to one tick per second. The count starts from a parameter value that is expressed as seconds since the start of 1904.

Top module: `clock_pram_serial`

## Requirements
- R1: After reset the seconds count equals INIT_SECONDS, write protect is clear, no command is pending and reply_bit is 0.
- R2: While host_pb[2] (select, active low) is 1, clock edges have no effect: no bit is shifted in or out.
- R3: With host_data_dir = 1, each rising edge of host_pb[1] samples host_pb[0]. Bits arrive MSB first and every 8 of them form one byte.
- R4: With host_data_dir = 0, each falling edge of host_pb[1] puts the next reply bit on reply_bit, MSB first, for 8 edges. After the 8th, reply_bit holds its last value.
- R5: When no command is pending, the read code 0x81 | (k << 2), for k from 0 to 3, returns seconds byte k. Byte 0 is the least significant.
- R6: The seconds count increments once every TICK_DIV clock cycles, and carries propagate across all four bytes.
- R7: The write code 0x01 | (k << 2) followed by a data byte loads seconds byte k. The load restarts the prescaler, and it takes priority over a tick that falls in the same cycle.
- R8: The codes 0xA1 | (i << 2) (read) and 0x21 | (i << 2) followed by a data byte (write) access store byte i, for i from 0 to 3.
- R9: The code 0xB8 | s followed by an address byte returns store byte s*8 + a, where a is address-byte bits 6:2. The sequence 0x38 | s, then the address byte, then a data byte writes that same byte.
- R10: The code 0x35 followed by a data byte sets write protect to data bit 0. While it is set, every other write (seconds, window, extended) is dropped.
- R11: The code 0x31 followed by a data byte changes nothing. The byte after that is decoded as a new command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_pb | input | 3 | Host port lines: bit 0 data, bit 1 serial clock, bit 2 select (active low) |
| host_data_dir | input | 1 | 1 when the host drives the data line, 0 when it reads it |
| reply_bit | output | 1 | Serial reply bit presented to the host |

## Verification
Two functions can act on the seconds register in the same cycle: a load of a seconds byte that arrives on a serial edge, and the prescaler's once-per-period tick. The bench provokes this collision by repeating a load-then-read pair, delaying its start by one extra cycle each time, across a whole prescaler period, so that the committing edge lands on every phase, including the tick phase. A correct design returns the same value on every repetition: the loaded value plus the number of whole periods that elapse between the load and the read, counted from the edges the bench itself generated.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int BYTE_W = 8;
  localparam int PB_DATA = 0;
  localparam int PB_SCLK = 1;
  localparam int PB_SEL = 2;

  localparam logic [7:0] REG_MASK = 8'hF3;
  localparam logic [7:0] EXT_MASK = 8'hF8;
  localparam logic [7:0] SEC_RD = 8'h81;
  localparam logic [7:0] SEC_WR = 8'h01;
  localparam logic [7:0] WIN_RD = 8'hA1;
  localparam logic [7:0] WIN_WR = 8'h21;
  localparam logic [7:0] EXT_RD = 8'hB8;
  localparam logic [7:0] EXT_WR = 8'h38;
  localparam logic [7:0] WP_CODE = 8'h35;
  localparam logic [7:0] TEST_CODE = 8'h31;

  // store index for a sector/address pair: sector*8 + address
  function automatic logic [7:0] ext_index(input logic [2:0] sec, input logic [4:0] adr);
    return {2'b00, sec, 3'b000} + {3'b000, adr};
  endfunction
endpackage

// File: rtl/cps_serial.sv
module cps_serial
  import cps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [2:0]        pb_i,
  input  logic              dir_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_byte_i,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              sdo_o
);
  localparam int CW = $clog2(BYTE_W + 1);

  logic              sclk_q, sclk_d;
  logic [BYTE_W-2:0] rx_q, rx_d;
  logic [CW-1:0]     rxc_q, rxc_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [CW-1:0]     txc_q, txc_d;
  logic              sdo_q, sdo_d;
  logic              sel, rise, fall;

  assign sel  = ~pb_i[PB_SEL];
  assign rise = sel & pb_i[PB_SCLK] & ~sclk_q;
  assign fall = sel & ~pb_i[PB_SCLK] & sclk_q;

  assign byte_valid_o = rise & dir_i & (rxc_q == CW'(BYTE_W - 1));
  assign byte_o       = {rx_q, pb_i[PB_DATA]};
  assign sdo_o        = sdo_q;

  always_comb begin
    sclk_d = pb_i[PB_SCLK];
    rx_d   = rx_q;
    rxc_d  = rxc_q;
    tx_d   = tx_q;
    txc_d  = txc_q;
    sdo_d  = sdo_q;
    if (rise && dir_i) begin
      rx_d  = {rx_q[BYTE_W-3:0], pb_i[PB_DATA]};
      rxc_d = (rxc_q == CW'(BYTE_W - 1)) ? '0 : rxc_q + 1'b1;
    end
    if (load_i) begin
      tx_d  = load_byte_i;
      txc_d = CW'(BYTE_W);
    end else if (fall && !dir_i && (txc_q != '0)) begin
      sdo_d = tx_q[BYTE_W-1];
      tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
      txc_d = txc_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      rx_q   <= '0;
      rxc_q  <= '0;
      tx_q   <= '0;
      txc_q  <= '0;
      sdo_q  <= 1'b0;
    end else begin
      sclk_q <= sclk_d;
      rx_q   <= rx_d;
      rxc_q  <= rxc_d;
      tx_q   <= tx_d;
      txc_q  <= txc_d;
      sdo_q  <= sdo_d;
    end
  end
endmodule

// File: rtl/cps_seconds.sv
module cps_seconds
  import cps_pkg::*;
#(
  parameter int          TICK_DIV     = 50_000_000,
  parameter logic [31:0] INIT_SECONDS = 32'hD0C0_1000
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [3:0]        ld_mask_i,
  input  logic [BYTE_W-1:0] ld_byte_i,
  output logic [31:0]       secs_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [31:0]   secs_q, secs_d;
  logic [31:0]   loaded;

  // per-lane load mux
  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign loaded[BYTE_W*k +: BYTE_W] = ld_mask_i[k] ? ld_byte_i : secs_q[BYTE_W*k +: BYTE_W];
  end

  always_comb begin
    pre_d  = pre_q;
    secs_d = secs_q;
    if (|ld_mask_i) begin
      pre_d  = '0;
      secs_d = loaded;
    end else if (pre_q == LAST) begin
      pre_d  = '0;
      secs_d = secs_q + 32'd1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      secs_q <= INIT_SECONDS;
    end else begin
      pre_q  <= pre_d;
      secs_q <= secs_d;
    end
  end

  assign secs_o = secs_q;
endmodule

// File: rtl/cps_store.sv
module cps_store
  import cps_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/cps_cmd.sv
module cps_cmd
  import cps_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [31:0]       secs_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic [AW-1:0]     mem_raddr_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_waddr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic [3:0]        ld_mask_o,
  output logic [BYTE_W-1:0] ld_byte_o,
  output logic              reply_load_o,
  output logic [BYTE_W-1:0] reply_byte_o,
  output logic              wp_o
);
  logic        pend_q, pend_d;
  logic [7:0]  cmd_q, cmd_d;
  logic        av_q, av_d;
  logic [4:0]  adr_q, adr_d;
  logic        wp_q, wp_d;

  assign mem_wdata_o = byte_i;
  assign ld_byte_o   = byte_i;
  assign wp_o        = wp_q;

  always_comb begin
    mem_raddr_o = pend_q ? AW'(ext_index(cmd_q[2:0], byte_i[6:2]))
                         : AW'(byte_i[3:2]);
  end

  always_comb begin
    pend_d       = pend_q;
    cmd_d        = cmd_q;
    av_d         = av_q;
    adr_d        = adr_q;
    wp_d         = wp_q;
    mem_we_o     = 1'b0;
    mem_waddr_o  = '0;
    ld_mask_o    = '0;
    reply_load_o = 1'b0;
    reply_byte_o = '0;
    if (byte_valid_i) begin
      if (!pend_q) begin
        if (byte_i[7]) begin
          if ((byte_i & REG_MASK) == SEC_RD) begin
            reply_load_o = 1'b1;
            reply_byte_o = secs_i[{byte_i[3:2], 3'b000} +: BYTE_W];
          end else if ((byte_i & REG_MASK) == WIN_RD) begin
            reply_load_o = 1'b1;
            reply_byte_o = mem_rdata_i;
          end else if ((byte_i & EXT_MASK) == EXT_RD) begin
            pend_d = 1'b1;
            cmd_d  = byte_i;
          end
        end else begin
          pend_d = 1'b1;
          cmd_d  = byte_i;
        end
      end else if (cmd_q[7]) begin
        // second byte of an extended read
        reply_load_o = 1'b1;
        reply_byte_o = mem_rdata_i;
        pend_d       = 1'b0;
      end else if ((cmd_q & EXT_MASK) == EXT_WR) begin
        if (!av_q) begin
          av_d  = 1'b1;
          adr_d = byte_i[6:2];
        end else begin
          av_d   = 1'b0;
          pend_d = 1'b0;
          if (!wp_q) begin
            mem_we_o    = 1'b1;
            mem_waddr_o = AW'(ext_index(cmd_q[2:0], adr_q));
          end
        end
      end else begin
        pend_d = 1'b0;
        if (cmd_q == WP_CODE) begin
          wp_d = byte_i[0];
        end else if (!wp_q) begin
          if ((cmd_q & REG_MASK) == SEC_WR) begin
            ld_mask_o[cmd_q[3:2]] = 1'b1;
          end else if ((cmd_q & REG_MASK) == WIN_WR) begin
            mem_we_o    = 1'b1;
            mem_waddr_o = AW'(cmd_q[3:2]);
          end
          // TEST_CODE and unknown codes fall through with no effect
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cmd_q  <= '0;
      av_q   <= 1'b0;
      adr_q  <= '0;
      wp_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      cmd_q  <= cmd_d;
      av_q   <= av_d;
      adr_q  <= adr_d;
      wp_q   <= wp_d;
    end
  end
endmodule

// File: rtl/clock_pram_serial.sv
module clock_pram_serial
  import cps_pkg::*;
#(
  parameter int          TICK_DIV     = 50_000_000,
  parameter logic [31:0] INIT_SECONDS = 32'hD0C0_1000,
  parameter int          RAM_DEPTH    = 256,
  localparam int         AW           = $clog2(RAM_DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] host_pb,
  input  logic       host_data_dir,
  output logic       reply_bit
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              byte_valid;
  logic [BYTE_W-1:0] rx_byte;
  logic              reply_load;
  logic [BYTE_W-1:0] reply_byte;
  logic [31:0]       secs;
  logic [3:0]        sec_ld_mask;
  logic [BYTE_W-1:0] sec_ld_byte;
  logic [AW-1:0]     mem_raddr, mem_waddr;
  logic [BYTE_W-1:0] mem_rdata, mem_wdata;
  logic              mem_we;
  logic              wp_flag;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cps_serial u_serial (
    .clk(clk), .rst_ni(rst_int_n), .pb_i(host_pb), .dir_i(host_data_dir),
    .load_i(reply_load), .load_byte_i(reply_byte),
    .byte_valid_o(byte_valid), .byte_o(rx_byte), .sdo_o(reply_bit)
  );

  cps_cmd #(.DEPTH(RAM_DEPTH)) u_cmd (
    .clk(clk), .rst_ni(rst_int_n), .byte_valid_i(byte_valid), .byte_i(rx_byte),
    .secs_i(secs), .mem_rdata_i(mem_rdata), .mem_raddr_o(mem_raddr),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata),
    .ld_mask_o(sec_ld_mask), .ld_byte_o(sec_ld_byte),
    .reply_load_o(reply_load), .reply_byte_o(reply_byte), .wp_o(wp_flag)
  );

  cps_seconds #(.TICK_DIV(TICK_DIV), .INIT_SECONDS(INIT_SECONDS)) u_secs (
    .clk(clk), .rst_ni(rst_int_n), .ld_mask_i(sec_ld_mask),
    .ld_byte_i(sec_ld_byte), .secs_o(secs)
  );

  cps_store #(.DEPTH(RAM_DEPTH)) u_store (
    .clk(clk), .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(mem_wdata),
    .raddr_i(mem_raddr), .rdata_o(mem_rdata)
  );
endmodule

// File: rtl/cps_checker.sv
module cps_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  pb,
  input logic        dir,
  input logic        sdo,
  input logic        byte_valid,
  input logic        reply_load,
  input logic        mem_we,
  input logic        wp,
  input logic [31:0] secs,
  input logic [3:0]  sec_ld
);
  assert_sel_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pb[2] |=> $stable(sdo));

  assert_byte_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> (dir && pb[1] && !pb[2]));

  assert_reply_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo != $past(sdo)) |-> $past(!dir && !pb[1] && !pb[2]));

  assert_reply_after_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reply_load |-> byte_valid);

  assert_secs_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(|sec_ld) |-> (secs == $past(secs) || secs == $past(secs) + 32'd1));

  assert_protect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wp |-> (!mem_we && sec_ld == 4'b0000));
endmodule

bind clock_pram_serial cps_checker chk_i (
  .clk(clk), .rst_n(rst_n), .pb(host_pb), .dir(host_data_dir), .sdo(reply_bit),
  .byte_valid(byte_valid), .reply_load(reply_load), .mem_we(mem_we),
  .wp(wp_flag), .secs(secs), .sec_ld(sec_ld_mask)
);

// File: tb/clock_pram_serial_tb.sv
`timescale 1ns/1ps
module clock_pram_serial_tb_top;
  localparam int P = 16;
  localparam int H = 2;
  localparam logic [31:0] INIT = 32'hD0C0_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] pb = 3'b100;
  logic dir = 1'b1;
  logic sdo;
  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int last_rise = 0;
  logic [7:0] model [256];
  logic [31:0] sec_base;
  int sec_ref;
  bit wp_m = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clock_pram_serial #(.TICK_DIV(P), .INIT_SECONDS(INIT), .RAM_DEPTH(256)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_pb(pb), .host_data_dir(dir), .reply_bit(sdo));

  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tx_byte(input logic [7:0] b);
    dir = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      pb[0] = b[i]; pb[1] = 1'b0;
      repeat (H) @(negedge clk);
      pb[1] = 1'b1; last_rise = cyc + 1;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic rx_byte(output logic [7:0] b);
    dir = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      pb[1] = 1'b1;
      repeat (H) @(negedge clk);
      pb[1] = 1'b0;
      repeat (H) @(negedge clk);
      b[i] = sdo;
    end
  endtask

  function automatic logic [31:0] secs_at(input int c);
    return sec_base + 32'((c - sec_ref - 1) / P);
  endfunction

  task automatic wr_sec(input int k, input logic [7:0] v);
    logic [31:0] cur;
    tx_byte(8'h01 | 8'(k << 2)); tx_byte(v);
    if (!wp_m) begin
      cur = secs_at(last_rise);
      cur[8*k +: 8] = v;
      sec_base = cur; sec_ref = last_rise;
    end
  endtask

  task automatic rd_sec(input int k, output logic [7:0] v, output logic [7:0] e);
    logic [31:0] s;
    tx_byte(8'h81 | 8'(k << 2));
    s = secs_at(last_rise);
    e = s[8*k +: 8];
    rx_byte(v);
  endtask

  task automatic win_wr(input int i, input logic [7:0] v);
    tx_byte(8'h21 | 8'(i << 2)); tx_byte(v);
    if (!wp_m) model[i] = v;
  endtask

  task automatic win_rd(input int i, output logic [7:0] v);
    tx_byte(8'hA1 | 8'(i << 2)); rx_byte(v);
  endtask

  task automatic ext_wr(input int s, input int a, input logic [7:0] v);
    tx_byte(8'h38 | 8'(s)); tx_byte(8'(a << 2)); tx_byte(v);
    if (!wp_m) model[s*8 + a] = v;
  endtask

  task automatic ext_rd(input int s, input int a, output logic [7:0] v);
    tx_byte(8'hB8 | 8'(s)); tx_byte(8'(a << 2)); rx_byte(v);
  endtask

  initial begin
    logic [7:0] v, e;
    int av[4];
    av[0] = 0; av[1] = 3; av[2] = 7; av[3] = 31;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 reply_bit after reset", 32'(sdo), 32'd0);
    pb[2] = 1'b0;

    // R1/R5: upper seconds bytes equal the reset value
    for (int k = 3; k >= 1; k--) begin
      tx_byte(8'h81 | 8'(k << 2)); rx_byte(v);
      check("R1 R5 seconds after reset", 32'(v), 32'(INIT[8*k +: 8]));
    end

    // R3 R8: window write/read sweep
    for (int i = 0; i < 4; i++) win_wr(i, 8'h40 + 8'(i * 7));
    for (int i = 0; i < 4; i++) begin
      win_rd(i, v);
      check("R3 R8 window readback", 32'(v), 32'(model[i]));
    end
    // R9: window aliases sector 0 of extended space
    for (int i = 0; i < 4; i++) begin
      ext_rd(0, i, v);
      check("R9 alias window via extended read", 32'(v), 32'(model[i]));
    end

    // R9: extended sweep over all sectors
    for (int s = 0; s < 8; s++)
      for (int j = 0; j < 4; j++)
        if (j < 3 || s == 7) ext_wr(s, av[j], 8'(s * 37 + av[j] * 11 + 3));
    for (int s = 0; s < 8; s++)
      for (int j = 0; j < 4; j++)
        if (j < 3 || s == 7) begin
          ext_rd(s, av[j], v);
          check("R9 extended readback", 32'(v), 32'(model[s*8 + av[j]]));
        end

    // R4: reply exhausted holds last bit
    win_rd(1, v);
    check("R4 reply byte", 32'(v), 32'(model[1]));
    rx_byte(v);
    check("R4 hold after 8 bits", 32'(v), 32'({8{model[1][0]}}));

    // R2: select high ignores a whole window write
    pb[2] = 1'b1;
    tx_byte(8'h21); tx_byte(8'hEE);
    pb[2] = 1'b0;
    win_rd(0, v);
    check("R2 ignored while deselected", 32'(v), 32'(model[0]));

    // R7 R5 R6: load seconds, let it run with carries
    tx_byte(8'h0D); tx_byte(8'h12);
    tx_byte(8'h09); tx_byte(8'h34);
    tx_byte(8'h05); tx_byte(8'hFF);
    tx_byte(8'h01); tx_byte(8'hF0);
    sec_base = 32'h1234_FFF0; sec_ref = last_rise;
    repeat (300) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      rd_sec(k, v, e);
      check("R5 R6 seconds byte after run", 32'(v), 32'(e));
    end
    check("R6 carry reached byte2", 32'(secs_at(cyc)) >> 16, 32'h1235);

    // R7: load landing on every prescaler phase
    for (int off = 0; off < P; off++) begin
      repeat (off) @(negedge clk);
      wr_sec(0, 8'h20);
      rd_sec(0, v, e);
      check("R7 load vs tick collision", 32'(v), 32'(e));
    end

    // R10: write protect blocks writes
    tx_byte(8'h35); tx_byte(8'h01); wp_m = 1'b1;
    win_wr(1, 8'h99);
    ext_wr(2, 3, 8'h5A);
    wr_sec(3, 8'hAA);
    win_rd(1, v);
    check("R10 window write blocked", 32'(v), 32'(model[1]));
    ext_rd(2, 3, v);
    check("R10 extended write blocked", 32'(v), 32'(model[2*8 + 3]));
    rd_sec(3, v, e);
    check("R10 seconds write blocked", 32'(v), 32'(e));
    tx_byte(8'h35); tx_byte(8'h00); wp_m = 1'b0;
    win_wr(1, 8'h3C);
    win_rd(1, v);
    check("R10 write after unprotect", 32'(v), 32'h3C);

    // R11: test code is inert, next byte is a command
    tx_byte(8'h31); tx_byte(8'h77);
    win_rd(2, v);
    check("R11 test code no effect", 32'(v), 32'(model[2]));
    rd_sec(2, v, e);
    check("R11 seconds untouched", 32'(v), 32'(e));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule